// File: doc/BRIEF.md
# Bus Parity Generator and Checker

This block produces and checks the even parity bit of a 32-bit multiplexed address/data bus. It watches the frame, initiator-ready and target-ready strobes together with the command/byte-enable lines and a role input that says whether this agent is the initiator (master) or the responder (target). From these signals it tracks the transaction and works out which agent drives address/data in each clock.

In every clock where this agent drives the bus, the block registers the parity of the 36 address/data and command/byte-enable bits. It presents that bit on the parity output one clock later and raises the parity output-enable in that clock. In every clock where the other agent drove a phase that counts, it registers the expected parity. One clock later it compares that value with the received parity pin and pulses an error strobe on a mismatch.

The strobe pins are active-low. The bus is idle in a clock where frame and initiator-ready are both high. Reporting the error to the rest of the system and the 64-bit extension are handled elsewhere.

Top module: `pci_par_unit`

## Requirements
- R1: The parity bit is the XOR of all 32 address/data bits and all 4 command/byte-enable bits, so the 37 bits including parity hold an even number of ones.
- R2: An address phase is a clock with frame low and no transaction open. A transaction opens after reset or after a clock with frame and initiator-ready both high. As master, the block drives parity for the address phase in the following clock.
- R3: In the address phase the command bit on command/byte-enable line 0 marks the direction: 1 is a write and 0 is a read. As master of a write, the block drives parity in the clock after each data clock with initiator-ready low, whatever target-ready shows.
- R4: As target of a read, the block drives parity in the clock after each data clock with target-ready low.
- R5: The parity output-enable is high only in the clock after a clock this agent sourced. It stays low after idle clocks, after master read data and after target write data.
- R6: The block checks the target's address phase and each completed data phase (initiator-ready and target-ready both low) that the other agent drove. On a mismatch between the received parity and the expected value, the error strobe rises in the clock after the parity clock, for one clock per bad phase.
- R7: The error strobe stays low when the received parity is correct. It also stays low, whatever the parity pin shows, after an incomplete data clock and after phases this agent drove.
- R8: While reset is low, the parity output, its enable and the error strobe are held at 0.
- R9: A transaction stays open until the bus is idle. A frame-low clock inside an open transaction is treated as data, not as a new address phase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Bus clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ad_i | input | 32 | Address/data bus as seen on the pins |
| cbe_ni | input | 4 | Command / byte enables, active low |
| frame_ni | input | 1 | Frame strobe, active low |
| irdy_ni | input | 1 | Initiator ready, active low |
| trdy_ni | input | 1 | Target ready, active low |
| is_master_i | input | 1 | 1 when this agent is the initiator |
| par_i | input | 1 | Parity received from the pin |
| par_o | output | 1 | Generated parity |
| par_oe_o | output | 1 | Output enable for par_o |
| par_err_o | output | 1 | One-clock parity error strobe |

## Verification
A wrong open-transaction flag or a wrong latched direction shows at the ports within one clock. The output-enable then rises after a clock that belongs to the other agent, or the error strobe reports a phase that should not be checked. Because the phase flags are never read back, stimulus alternates idle, wait-state and completed clocks in both roles and both directions, so that each such fault is seen at par_oe_o or par_err_o. A stale parity register appears as a wrong par_o in the very next enabled clock. A mis-aligned compare appears two clocks after the phase it belongs to.

// File: rtl/pci_par_pkg.sv
package pci_par_pkg;
  // bit of the command nibble that separates writes (1) from reads (0)
  localparam int unsigned CMD_WR_BIT = 0;

  typedef struct packed {
    logic drive;  // this agent sources AD this clock
    logic check;  // other agent sourced a phase that counts
  } phase_dec_t;
endpackage

// File: rtl/pci_par_phase.sv
module pci_par_phase
  import pci_par_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       frame_ni,
  input  logic       irdy_ni,
  input  logic       trdy_ni,
  input  logic       is_master_i,
  input  logic       cmd_wr_i,
  output phase_dec_t dec_o
);
  logic in_txn_q, wr_q;
  logic addr_ph, idle, done;

  assign addr_ph = !frame_ni && !in_txn_q;
  assign idle    = frame_ni && irdy_ni;
  assign done    = in_txn_q && !irdy_ni && !trdy_ni;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      in_txn_q <= 1'b0;
      wr_q     <= 1'b0;
    end else if (addr_ph) begin
      in_txn_q <= 1'b1;
      wr_q     <= cmd_wr_i;
    end else if (idle) begin
      in_txn_q <= 1'b0;
    end
  end

  always_comb begin
    dec_o.drive = (addr_ph && is_master_i)
               || (in_txn_q &&  is_master_i &&  wr_q && !irdy_ni)
               || (in_txn_q && !is_master_i && !wr_q && !trdy_ni);
    // master-read or target-write data comes from the other side
    dec_o.check = (addr_ph && !is_master_i)
               || (done && (is_master_i != wr_q));
  end
endmodule

// File: rtl/pci_par_gen.sv
module pci_par_gen (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic drive_i,
  input  logic par_calc_i,
  output logic par_o,
  output logic par_oe_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      par_o    <= 1'b0;
      par_oe_o <= 1'b0;
    end else begin
      par_oe_o <= drive_i;
      if (drive_i) par_o <= par_calc_i;
    end
  end
endmodule

// File: rtl/pci_par_chk.sv
module pci_par_chk (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic check_i,
  input  logic par_calc_i,
  input  logic par_i,
  output logic err_o
);
  logic exp_q, armed_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      exp_q   <= 1'b0;
      armed_q <= 1'b0;
      err_o   <= 1'b0;
    end else begin
      exp_q   <= par_calc_i;
      armed_q <= check_i;
      err_o   <= armed_q && (par_i != exp_q);
    end
  end
endmodule

// File: rtl/pci_par_unit.sv
module pci_par_unit
  import pci_par_pkg::*;
#(
  parameter  int AD_W = 32,
  localparam int BE_W = AD_W / 8
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic [AD_W-1:0] ad_i,
  input  logic [BE_W-1:0] cbe_ni,
  input  logic            frame_ni,
  input  logic            irdy_ni,
  input  logic            trdy_ni,
  input  logic            is_master_i,
  input  logic            par_i,
  output logic            par_o,
  output logic            par_oe_o,
  output logic            par_err_o
);
  phase_dec_t dec;
  logic       par_calc;

  // even parity: XOR of every AD and C/BE bit
  assign par_calc = ^{ad_i, cbe_ni};

  pci_par_phase u_phase (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .frame_ni    (frame_ni),
    .irdy_ni     (irdy_ni),
    .trdy_ni     (trdy_ni),
    .is_master_i (is_master_i),
    .cmd_wr_i    (cbe_ni[CMD_WR_BIT]),
    .dec_o       (dec)
  );

  pci_par_gen u_gen (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .drive_i    (dec.drive),
    .par_calc_i (par_calc),
    .par_o      (par_o),
    .par_oe_o   (par_oe_o)
  );

  pci_par_chk u_chk (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .check_i    (dec.check),
    .par_calc_i (par_calc),
    .par_i      (par_i),
    .err_o      (par_err_o)
  );
endmodule

// File: rtl/pci_par_unit_sva.sv
module pci_par_unit_sva #(
  parameter  int AD_W = 32,
  localparam int BE_W = AD_W / 8
) (
  input logic            clk_i,
  input logic            rst_ni,
  input logic [AD_W-1:0] ad_i,
  input logic [BE_W-1:0] cbe_ni,
  input logic            frame_ni,
  input logic            irdy_ni,
  input logic            trdy_ni,
  input logic            is_master_i,
  input logic            par_i,
  input logic            par_o,
  input logic            par_oe_o,
  input logic            par_err_o
);
  a_r1_even_par: assert property (@(posedge clk_i) disable iff (!rst_ni)
    par_oe_o |-> (par_o == ^$past({ad_i, cbe_ni})));

  a_r5_oe_busy: assert property (@(posedge clk_i) disable iff (!rst_ni)
    par_oe_o |-> $past(!frame_ni || !irdy_ni));

  a_r6_err_cause: assert property (@(posedge clk_i) disable iff (!rst_ni)
    par_err_o |-> ($past(par_i) != ^$past({ad_i, cbe_ni}, 2)));

  a_r7_no_self_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    par_err_o |-> !$past(par_oe_o));

  a_r8_reset_clr: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(rst_ni) |-> (!par_oe_o && !par_err_o && !par_o));
endmodule

bind pci_par_unit pci_par_unit_sva #(.AD_W(AD_W)) u_sva (.*);

// File: tb/pci_par_unit_tb_top.sv
module pci_par_unit_tb_top;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [31:0] ad_i = '0;
  logic [3:0]  cbe_ni = 4'hF;
  logic        frame_ni = 1'b1, irdy_ni = 1'b1, trdy_ni = 1'b1;
  logic        is_master_i = 1'b1, par_i = 1'b0;
  logic        par_o, par_oe_o, par_err_o;

  int checks = 0, errors = 0;
  logic prev_par = 1'b0;

  always #4 clk_i = ~clk_i;

  pci_par_unit dut_i (.*);

  typedef struct packed {
    logic f, i, t, m;
    logic [31:0] ad;
    logic [3:0]  cbe;
    logic bad, eoe, eerr;
  } vec_t;

  localparam int NV = 20;
  // bad: par_i in this clock is wrong for the previous clock's data
  // cbe 7 = memory write (bit0=1), 6 = memory read (bit0=0)
  localparam vec_t VECS [NV] = '{
    '{1,1,1,1, 32'h0000_0000, 4'hF, 0, 0, 0},  // 0 idle
    '{0,1,1,1, 32'hFFFF_FFFF, 4'h7, 0, 1, 0},  // 1 R2 master write addr
    '{0,0,1,1, 32'h0000_0001, 4'h0, 0, 1, 0},  // 2 R3 irdy only
    '{0,0,0,1, 32'h1234_5678, 4'h0, 1, 1, 0},  // 3 R3/R7 own data, bad ignored
    '{1,0,0,1, 32'h8000_0000, 4'h3, 0, 1, 0},  // 4 R3 last
    '{1,1,1,1, 32'h0,         4'hF, 0, 0, 0},  // 5 R5 idle
    '{0,1,1,1, 32'hA5A5_0003, 4'h6, 0, 1, 0},  // 6 R2 master read addr
    '{1,0,0,1, 32'h0F0F_0F0E, 4'h0, 0, 0, 0},  // 7 R5 target drives
    '{1,1,1,1, 32'h0,         4'hF, 1, 0, 1},  // 8 R6 read data bad
    '{1,1,1,1, 32'h0,         4'hF, 0, 0, 0},  // 9 R6 one clock
    '{0,1,1,0, 32'h0000_00FF, 4'h7, 0, 0, 0},  // 10 target write addr
    '{0,0,1,0, 32'hDEAD_BEEF, 4'h0, 1, 0, 1},  // 11 R6 addr bad; wait clock
    '{0,0,0,0, 32'h0000_0007, 4'h0, 1, 0, 0},  // 12 R7 incomplete not checked
    '{1,0,0,0, 32'h7777_0000, 4'h1, 0, 0, 0},  // 13 R7 good parity
    '{1,1,1,0, 32'h0,         4'hF, 1, 0, 1},  // 14 R6 last data bad
    '{0,1,1,0, 32'h0000_0010, 4'h6, 0, 0, 0},  // 15 target read addr
    '{0,0,1,0, 32'h0000_0011, 4'h0, 0, 0, 0},  // 16 R4 trdy high
    '{0,0,0,0, 32'hC3C3_3C3C, 4'h2, 0, 1, 0},  // 17 R9 frame low = data; R4
    '{1,0,0,0, 32'h0000_0003, 4'h0, 1, 1, 0},  // 18 R4 still data; own, bad ignored
    '{1,1,1,0, 32'h0,         4'hF, 1, 0, 0}   // 19 R7 own data not checked
  };

  task automatic chk(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s act=%0b exp=%0b", req, act, exp);
    end
  endtask

  initial begin
    fork
      begin
        #400000;
        errors++;
        $display("FAIL watchdog act=timeout exp=done");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
      end
    join_none

    #2;
    chk("R8 reset oe", par_oe_o, 1'b0);
    chk("R8 reset err", par_err_o, 1'b0);
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;

    for (int k = 0; k < NV; k++) begin
      @(negedge clk_i);
      frame_ni = VECS[k].f; irdy_ni = VECS[k].i; trdy_ni = VECS[k].t;
      is_master_i = VECS[k].m; ad_i = VECS[k].ad; cbe_ni = VECS[k].cbe;
      par_i = prev_par ^ VECS[k].bad;
      prev_par = ^{VECS[k].ad, VECS[k].cbe};
      @(posedge clk_i);
      #2;
      chk($sformatf("R5 oe vec%0d", k), par_oe_o, VECS[k].eoe);
      chk($sformatf("R6 err vec%0d", k), par_err_o, VECS[k].eerr);
      if (VECS[k].eoe)
        chk($sformatf("R1 par vec%0d", k), par_o, prev_par);
    end

    // R1 corner: 36 ones gives parity 0
    @(negedge clk_i);
    frame_ni = 1'b0; irdy_ni = 1'b1; trdy_ni = 1'b1; is_master_i = 1'b1;
    ad_i = 32'hFFFF_FFFF; cbe_ni = 4'hF; par_i = 1'b0;
    @(posedge clk_i); #2;
    chk("R1 all ones", par_o, 1'b0);
    chk("R2 oe all ones", par_oe_o, 1'b1);

    // R8: reset mid-transaction clears enable at once
    @(negedge clk_i);
    frame_ni = 1'b0; irdy_ni = 1'b0; ad_i = 32'h1;
    rst_ni = 1'b0;
    #1;
    chk("R8 async oe", par_oe_o, 1'b0);
    chk("R8 async par", par_o, 1'b0);
    @(negedge clk_i);
    frame_ni = 1'b1; irdy_ni = 1'b1; rst_ni = 1'b1;
    @(posedge clk_i); #2;
    chk("R8 after release", par_oe_o, 1'b0);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule